// File: doc/BRIEF.md
# Vectored Interrupt Controller with Cascade Input

This block gathers up to 32 interrupt sources into one request line towards a processor. Software reaches it over a plain 32-bit register bus with separate write and read strobes, one address and one write-data word. Each source has a pending bit, an enable bit and a handling-mode bit. The request goes out when the master gate is open and at least one pending source is also enabled. Among the active sources, the lowest index always wins.

After reset the controller is in a software-test state. In that state, writes to the pending register create interrupts and the source pins are ignored. Setting the hardware-enable bit switches the controller over to real sources for good. Each source pin passes through a two-stage synchroniser and an edge detector before it can set its pending bit.

When the winning source is marked for fast handling, the controller adds a vector-valid strobe and the address held in that source's vector register. An acknowledge pulse from the processor then clears the serviced pending bit by itself. The top source can instead be built as a level input, which carries the request of a second controller of the same kind further down a chain.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the pending, enable and mode registers are zero, both control bits are clear, `irq_out` and `vec_valid` are low, the vector-number register reads all ones and every vector register reads 0x10.
- R2: `irq_out` is high exactly when control bit 0 (master gate, register 0x1C) is set and pending AND enable is non-zero. Register 0x04 reads pending AND enable.
- R3: Control bit 1 (hardware enable, register 0x1C) is set by writing 1 to it. Writing 0 to it never clears it; only reset does.
- R4: While hardware enable is clear, writing register 0x00 sets every pending bit written as 1, and the source pins have no effect. Once it is set, writes to 0x00 have no effect, and a rising edge on a source pin sets that pending bit at the third clock edge after the pin changes.
- R5: Writing a mask to register 0x0C clears each pending bit written as 1 and leaves the bits written as 0 alone. A set arriving in the same cycle as a clear of the same bit wins.
- R6: Clearing an enable bit (register 0x08) drops the request but keeps the pending bit. Enabling the bit again raises the request once more.
- R7: Register 0x18 returns the lowest index whose pending and enable bits are both set, or all ones when there is none.
- R8: When the winning source's mode bit (register 0x20, 1 = fast) is set and `irq_out` is high, `vec_valid` is high and `vec_addr` equals that source's vector register at 0x100 + 4*index. Otherwise `vec_valid` and `vec_addr` are zero.
- R9: A `vec_ack` pulse while `vec_valid` is high clears the winning source's pending bit at the clock edge after the one that samples the pulse.
- R10: With the cascade option on, the top source is level sensitive. Its pending bit is set again on every clock while its synchronised input is high, so an acknowledge does not drop it while the downstream request stays high.
- R11: Reads of register 0x0C, of unassigned offsets and of vector slots beyond the source count return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe, gates `bus_rdata` |
| bus_addr | input | 9 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| src_in | input | 32 | Interrupt source pins; top pin may carry a downstream request |
| vec_ack | input | 1 | Processor acknowledge of a vectored request |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Fast vector present on `vec_addr` |
| vec_addr | output | 32 | Vector address of the winning fast source |

## Verification
An edge-detected set of a pending bit and an acknowledge write that clears the same bit can fall in the same clock edge. The bench raises a source pin and counts the synchroniser stages, then places the acknowledge write so that it commits on exactly the edge where the detected rise lands. It expects the bit to survive and then confirms that a later, lone acknowledge clears it. The cascade input is judged the same way: an acknowledge lands while the level is still high, and the bit must stay set.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

   // Register offsets inside the low 256-byte window
   localparam logic [7:0] OFS_STATUS = 8'h00;
   localparam logic [7:0] OFS_PEND   = 8'h04;
   localparam logic [7:0] OFS_ENABLE = 8'h08;
   localparam logic [7:0] OFS_ACK    = 8'h0C;
   localparam logic [7:0] OFS_VNUM   = 8'h18;
   localparam logic [7:0] OFS_MASTER = 8'h1C;
   localparam logic [7:0] OFS_MODE   = 8'h20;

   // Bit positions inside the control register
   localparam int GATE_BIT = 0;
   localparam int HWEN_BIT = 1;

   typedef struct packed {
      logic status;
      logic pend;
      logic enable;
      logic ack;
      logic vnum;
      logic master;
      logic mode;
      logic bank;
   } ivc_hit_t;

endpackage

// File: rtl/ivc_edge_sync.sv
module ivc_edge_sync #(
   parameter int W         = 32,
   parameter bit LEVEL_TOP = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] src_i,
   output logic [W-1:0] set_o
);

   logic [W-1:0] meta_q;
   logic [W-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         sync_q <= '0;
      end else begin
         meta_q <= src_i;
         sync_q <= meta_q;
      end
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (LEVEL_TOP && (i == W - 1)) begin : g_level
         // chained request: follow the synchronised level
         assign set_o[i] = sync_q[i];
      end else begin : g_edge
         logic hist_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hist_q <= 1'b0;
            else        hist_q <= sync_q[i];
         end
         assign set_o[i] = sync_q[i] & ~hist_q;

         AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            set_o[i] |=> !set_o[i]); // R4
      end
   end

endmodule

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc #(
   parameter int W     = 32,
   parameter int IDX_W = $clog2(W)
) (
   input  logic [W-1:0]     req_i,
   output logic             found_o,
   output logic [IDX_W-1:0] idx_o
);

   always_comb begin
      found_o = |req_i;
      idx_o   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i);
      end
   end

endmodule

// File: rtl/ivc_vec_bank.sv
module ivc_vec_bank #(
   parameter int          DEPTH   = 32,
   parameter int          IDX_W   = $clog2(DEPTH),
   parameter int          DW      = 32,
   parameter int unsigned RST_VEC = 'h10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [DW-1:0]    wdata_i,
   input  logic [IDX_W-1:0] rd_a_idx_i,
   output logic [DW-1:0]    rd_a_o,
   input  logic [IDX_W-1:0] rd_b_idx_i,
   output logic [DW-1:0]    rd_b_o
);

   logic [DW-1:0] slot_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q[e] <= DW'(RST_VEC);
         else if (wr_i && (wr_idx_i == IDX_W'(e)))
            slot_q[e] <= wdata_i;
      end
   end

   assign rd_a_o = slot_q[rd_a_idx_i];
   assign rd_b_o = slot_q[rd_b_idx_i];

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import ivc_pkg::*;
#(
   parameter int          NUM_SRC    = 32,
   parameter int          DATA_W     = 32,
   parameter int          ADDR_W     = 9,
   parameter bit          CASCADE_EN = 1'b1,
   parameter int unsigned RESET_VEC  = 'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic              vec_ack,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_out,
   output logic              vec_valid,
   output logic [DATA_W-1:0] vec_addr
);

   localparam int         IDX_W = $clog2(NUM_SRC);
   localparam logic [5:0] SLOTS = 6'(NUM_SRC);

   if (NUM_SRC < 2 || NUM_SRC > 32) begin : g_bad_src
      $error("NUM_SRC must lie in 2..32");
   end
   if (DATA_W < NUM_SRC) begin : g_bad_data
      $error("DATA_W must cover NUM_SRC");
   end
   if (ADDR_W < 9) begin : g_bad_addr
      $error("ADDR_W must reach the vector window");
   end

   // ---------------- address decode ----------------
   ivc_hit_t         hit;
   logic             lo_region;
   logic             bank_region;
   logic [5:0]       slot;
   logic [NUM_SRC-1:0] wdata_src;

   assign lo_region   = (bus_addr[ADDR_W-1:8] == '0);
   assign slot        = bus_addr[7:2];
   assign bank_region = (bus_addr[ADDR_W-1:8] == (ADDR_W-8)'(1)) &&
                        (bus_addr[1:0] == 2'b00) && (slot < SLOTS);
   assign wdata_src   = bus_wdata[NUM_SRC-1:0];

   always_comb begin
      hit = '0;
      if (lo_region) begin
         case (bus_addr[7:0])
            OFS_STATUS: hit.status = 1'b1;
            OFS_PEND:   hit.pend   = 1'b1;
            OFS_ENABLE: hit.enable = 1'b1;
            OFS_ACK:    hit.ack    = 1'b1;
            OFS_VNUM:   hit.vnum   = 1'b1;
            OFS_MASTER: hit.master = 1'b1;
            OFS_MODE:   hit.mode   = 1'b1;
            default:    ;
         endcase
      end
      hit.bank = bank_region;
   end

   // ---------------- source front end ----------------
   logic [NUM_SRC-1:0] edge_set;

   ivc_edge_sync #(
      .W         (NUM_SRC),
      .LEVEL_TOP (CASCADE_EN)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .src_i (src_in),
      .set_o (edge_set)
   );

   // ---------------- state ----------------
   logic [NUM_SRC-1:0] status_q, enable_q, mode_q;
   logic               gate_q, hwen_q;
   logic               ack_pend_q;
   logic [IDX_W-1:0]   ack_idx_q;
   logic [NUM_SRC-1:0] set_vec, clr_vec, active;
   logic               win_found;
   logic [IDX_W-1:0]   win_idx;

   assign set_vec = hwen_q ? edge_set
                  : ((bus_wr && hit.status) ? wdata_src : '0);
   assign clr_vec = ((bus_wr && hit.ack) ? wdata_src : '0) |
                    (ack_pend_q ? (NUM_SRC'(1) << ack_idx_q) : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q   <= '0;
         enable_q   <= '0;
         mode_q     <= '0;
         gate_q     <= 1'b0;
         hwen_q     <= 1'b0;
         ack_pend_q <= 1'b0;
         ack_idx_q  <= '0;
      end else begin
         status_q <= (status_q & ~clr_vec) | set_vec;
         if (bus_wr && hit.enable) enable_q <= wdata_src;
         if (bus_wr && hit.mode)   mode_q   <= wdata_src;
         if (bus_wr && hit.master) begin
            gate_q <= bus_wdata[GATE_BIT];
            if (bus_wdata[HWEN_BIT]) hwen_q <= 1'b1;
         end
         ack_pend_q <= vec_ack && vec_valid;
         ack_idx_q  <= win_idx;
      end
   end

   // ---------------- arbitration and request ----------------
   assign active = status_q & enable_q;

   ivc_prio_enc #(
      .W     (NUM_SRC),
      .IDX_W (IDX_W)
   ) u_prio (
      .req_i   (active),
      .found_o (win_found),
      .idx_o   (win_idx)
   );

   assign irq_out = gate_q && (|active);

   // ---------------- vector bank ----------------
   logic [DATA_W-1:0] bank_bus_rd, bank_vec_rd;

   ivc_vec_bank #(
      .DEPTH   (NUM_SRC),
      .IDX_W   (IDX_W),
      .DW      (DATA_W),
      .RST_VEC (RESET_VEC)
   ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (bus_wr && hit.bank),
      .wr_idx_i   (slot[IDX_W-1:0]),
      .wdata_i    (bus_wdata),
      .rd_a_idx_i (slot[IDX_W-1:0]),
      .rd_a_o     (bank_bus_rd),
      .rd_b_idx_i (win_idx),
      .rd_b_o     (bank_vec_rd)
   );

   assign vec_valid = irq_out && mode_q[win_idx];
   assign vec_addr  = vec_valid ? bank_vec_rd : '0;

   // ---------------- read path ----------------
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      if (hit.status)      rd_mux = DATA_W'(status_q);
      else if (hit.pend)   rd_mux = DATA_W'(active);
      else if (hit.enable) rd_mux = DATA_W'(enable_q);
      else if (hit.vnum)   rd_mux = win_found ? DATA_W'(win_idx) : '1;
      else if (hit.master) rd_mux = DATA_W'({hwen_q, gate_q});
      else if (hit.mode)   rd_mux = DATA_W'(mode_q);
      else if (hit.bank)   rd_mux = bank_bus_rd;
   end

   assign bus_rdata = bus_rd ? rd_mux : '0;

   // ---------------- assertions ----------------
   AST_HWEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hwen_q) |-> hwen_q); // R3

   AST_SIM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (!hwen_q && !(bus_wr && hit.status)) |=> ((status_q & ~$past(status_q)) == '0)); // R4

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit.ack) |=> ((status_q & $past(wdata_src) & ~$past(set_vec)) == '0)); // R5

   AST_IRQ_HAS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (win_found && active[win_idx])); // R7

   AST_WINNER_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      win_found |-> ((active & ((NUM_SRC'(1) << win_idx) - NUM_SRC'(1))) == '0)); // R7

   AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_pend_q && !set_vec[ack_idx_q]) |=> !status_q[$past(ack_idx_q)]); // R9

endmodule

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;

   localparam logic [8:0] A_STATUS = 9'h000;
   localparam logic [8:0] A_PEND   = 9'h004;
   localparam logic [8:0] A_ENABLE = 9'h008;
   localparam logic [8:0] A_ACK    = 9'h00C;
   localparam logic [8:0] A_VNUM   = 9'h018;
   localparam logic [8:0] A_MASTER = 9'h01C;
   localparam logic [8:0] A_MODE   = 9'h020;

   localparam int SEL_RD   = 0;
   localparam int SEL_IRQ  = 1;
   localparam int SEL_VV   = 2;
   localparam int SEL_VA   = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [8:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] src_in = '0;
   logic        vec_ack = 1'b0;
   logic [31:0] bus_rdata;
   logic        irq_out;
   logic        vec_valid;
   logic [31:0] vec_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int          q_sel[$];
   logic [31:0] q_exp[$];
   string       q_tag[$];

   always #2 clk = ~clk;

   irq_vector_ctrl i_irq_vector_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .src_in    (src_in),
      .vec_ack   (vec_ack),
      .bus_rdata (bus_rdata),
      .irq_out   (irq_out),
      .vec_valid (vec_valid),
      .vec_addr  (vec_addr)
   );

   // ---------------- driver side ----------------
   task automatic push(input int sel, input logic [31:0] exp, input string tag);
      q_sel.push_back(sel);
      q_exp.push_back(exp);
      q_tag.push_back(tag);
   endtask

   task automatic wr(input logic [8:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_rd    = 1'b0;
      bus_wr    = 1'b1;
      bus_addr  = a;
      bus_wdata = d;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd_now(input logic [8:0] a, input logic [31:0] exp, input string tag);
      bus_rd   = 1'b1;
      bus_addr = a;
      push(SEL_RD, exp, tag);
   endtask

   task automatic exp_rd(input logic [8:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      rd_now(a, exp, tag);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // ---------------- monitor / scoreboard ----------------
   initial begin
      forever begin
         wait (q_sel.size() != 0);
         #0.5;
         begin
            int          sel;
            logic [31:0] exp;
            logic [31:0] act;
            string       tag;
            sel = q_sel.pop_front();
            exp = q_exp.pop_front();
            tag = q_tag.pop_front();
            case (sel)
               SEL_RD:  act = bus_rdata;
               SEL_IRQ: act = {31'b0, irq_out};
               SEL_VV:  act = {31'b0, vec_valid};
               default: act = vec_addr;
            endcase
            checks++;
            if (act !== exp) begin
               errors++;
               $display("FAIL %s actual=%h expected=%h", tag, act, exp);
            end
         end
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      idle(3);
      rst_n = 1'b1;

      // R1 reset state
      exp_rd(A_STATUS, 32'h0, "R1 status after reset");
      exp_rd(A_ENABLE, 32'h0, "R1 enable after reset");
      exp_rd(A_MASTER, 32'h0, "R1 control after reset");
      exp_rd(A_VNUM, 32'hFFFF_FFFF, "R1 vector number idle");
      exp_rd(9'h100, 32'h10, "R1 vector slot 0 default");
      exp_rd(9'h17C, 32'h10, "R1 vector slot 31 default");
      push(SEL_IRQ, 32'h0, "R1 irq low");
      push(SEL_VV, 32'h0, "R1 vec_valid low");

      // R4 software-set path, R2 gating
      wr(A_STATUS, 32'h24);
      exp_rd(A_STATUS, 32'h24, "R4 software set");
      exp_rd(A_PEND, 32'h0, "R2 pending masked by enable");
      wr(A_ENABLE, 32'h20);
      exp_rd(A_PEND, 32'h20, "R2 pending register");
      push(SEL_IRQ, 32'h0, "R2 irq blocked by gate");
      wr(A_MASTER, 32'h1);
      push(SEL_IRQ, 32'h1, "R2 irq with gate open");
      exp_rd(A_VNUM, 32'd5, "R7 single winner");
      wr(A_ENABLE, 32'h24);
      exp_rd(A_VNUM, 32'd2, "R7 lower index wins");

      // R4 pins ignored before hardware enable
      @(negedge clk); src_in[3] = 1'b1;
      idle(4);
      exp_rd(A_STATUS, 32'h24, "R4 pin ignored in sim mode");

      // R5 acknowledge mask
      wr(A_ACK, 32'h04);
      exp_rd(A_STATUS, 32'h20, "R5 masked clear");
      wr(A_ACK, 32'h0);
      exp_rd(A_STATUS, 32'h20, "R5 zero mask no effect");

      // R6 disable keeps pending
      wr(A_ENABLE, 32'h0);
      push(SEL_IRQ, 32'h0, "R6 irq dropped when disabled");
      exp_rd(A_STATUS, 32'h20, "R6 pending held");
      wr(A_ENABLE, 32'h20);
      push(SEL_IRQ, 32'h1, "R6 irq back on re-enable");
      wr(A_ACK, 32'h20);
      push(SEL_IRQ, 32'h0, "R5 irq after clear");

      // R3 sticky hardware enable
      wr(A_MASTER, 32'h3);
      exp_rd(A_MASTER, 32'h3, "R3 both bits set");
      wr(A_MASTER, 32'h0);
      exp_rd(A_MASTER, 32'h2, "R3 hw enable survives zero write");
      wr(A_MASTER, 32'h1);
      exp_rd(A_MASTER, 32'h3, "R3 gate back on");

      // R4 hardware mode
      wr(A_STATUS, 32'h1);
      exp_rd(A_STATUS, 32'h0, "R4 status write locked");
      @(negedge clk); src_in[3] = 1'b0;
      @(negedge clk); src_in[7] = 1'b1;
      idle(3);
      exp_rd(A_STATUS, 32'h80, "R4 edge sets pending");

      // R5 set and clear in the same edge
      @(negedge clk); src_in[9] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = A_ACK; bus_wdata = 32'h200;
      @(negedge clk);
      bus_wr = 1'b0;
      exp_rd(A_STATUS, 32'h280, "R5 set wins over clear");
      wr(A_ACK, 32'h200);
      exp_rd(A_STATUS, 32'h80, "R5 lone clear");

      // R8 fast vector, R9 auto clear
      wr(A_ENABLE, 32'h80);
      wr(A_MODE, 32'h80);
      wr(9'h11C, 32'hDEAD_BEE0);
      exp_rd(9'h11C, 32'hDEAD_BEE0, "R8 vector readback");
      push(SEL_VV, 32'h1, "R8 vec_valid fast");
      push(SEL_VA, 32'hDEAD_BEE0, "R8 vec_addr");
      @(negedge clk); vec_ack = 1'b1;
      @(negedge clk); vec_ack = 1'b0;
      rd_now(A_STATUS, 32'h80, "R9 clear is one cycle later");
      exp_rd(A_STATUS, 32'h0, "R9 auto clear");
      push(SEL_VV, 32'h0, "R9 vec_valid after clear");
      push(SEL_VA, 32'h0, "R8 vec_addr zero when invalid");

      // R8 normal source gives no vector
      wr(A_MODE, 32'h0);
      wr(A_ENABLE, 32'h10);
      @(negedge clk); src_in[4] = 1'b1;
      idle(3);
      push(SEL_IRQ, 32'h1, "R8 irq normal source");
      push(SEL_VV, 32'h0, "R8 no vector in normal mode");
      exp_rd(A_VNUM, 32'd4, "R7 normal winner index");
      wr(A_ACK, 32'h10);
      src_in[4] = 1'b0;

      // R10 cascade level input
      wr(A_ENABLE, 32'h8000_0000);
      @(negedge clk); src_in[31] = 1'b1;
      idle(3);
      exp_rd(A_STATUS, 32'h8000_0000, "R10 cascade sets");
      exp_rd(A_VNUM, 32'd31, "R10 cascade index");
      wr(A_ACK, 32'h8000_0000);
      exp_rd(A_STATUS, 32'h8000_0000, "R10 level holds through ack");
      @(negedge clk); src_in[31] = 1'b0;
      idle(3);
      wr(A_ACK, 32'h8000_0000);
      exp_rd(A_STATUS, 32'h0, "R10 cleared once level low");
      push(SEL_IRQ, 32'h0, "R10 irq low");

      // R11 zero reads
      exp_rd(A_ACK, 32'h0, "R11 ack reads zero");
      exp_rd(9'h014, 32'h0, "R11 unassigned offset");
      exp_rd(9'h180, 32'h0, "R11 beyond vector bank");

      wait (q_sel.size() == 0);
      idle(2);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule